// File: doc/BRIEF.md
# Two-Section Falling-Edge Counter (Divide-by-Two and Divide-by-Five)

This block is a four-bit counter made of two independent sections. The low section is one bit that toggles on every falling edge of its own count input. The high section is a three-bit counter that steps through 0, 1, 2, 3, 4 and wraps, advancing on falling edges of a second count input. Both count inputs are sampled on the system clock `clk` and must be synchronous to it. A falling edge is seen when one sample is high and the next is low.

Two gated overrides act on both sections. Clear needs both of its inputs high. Preset needs both of its inputs high and loads nine. An override reaches the outputs in the same cycle, without waiting for a clock edge, and it holds the state for as long as it is asserted.

The count inputs are not tied to the outputs inside the block. The wiring outside the block picks the mode:
- Feeding the low output into the high count input gives a decade counter in 8421 BCD order.
- Feeding the top bit of the high section into the low count input gives a symmetric divide-by-ten, in bi-quinary order.

Top module: `twosec_counter`

## Requirements
- R1: After `rst_n` has been low at a rising clock edge, `lo_q_o` reads 0 and `hi_q_o` reads 0.
- R2: `lo_q_o` inverts once for each falling edge of `cka_i`, one or two `clk` cycles after the first low sample. A rising edge of `cka_i` leaves `lo_q_o` unchanged.
- R3: `hi_q_o` steps 0, 1, 2, 3, 4, 0 on successive falling edges of `ckb_i`, and it never reads a value of 5 or above.
- R4: While `clr_a_i` and `clr_b_i` are both high, and preset is not active, both outputs read 0. This holds within the same clock cycle in which the pair becomes active.
- R5: `clr_a_i` or `clr_b_i` high on its own changes no output and does not stop counting.
- R6: While `set_a_i` and `set_b_i` are both high, the outputs read nine: `lo_q_o`=1 and `hi_q_o`=4 (binary 100). This holds within the same cycle. After release, the next falling edge of `ckb_i` takes `hi_q_o` from 4 to 0.
- R7: `set_a_i` or `set_b_i` high on its own changes no output and does not stop counting.
- R8: If the clear pair and the preset pair are both active, preset takes priority and the outputs read nine.
- R9: Falling edges that arrive while an override is active are discarded. The count starts again at the first falling edge after release.
- R10: With `ckb_i` driven from `lo_q_o` and the count applied to `cka_i`, the four-bit value {`hi_q_o`, `lo_q_o`} runs 0, 1, …, 9 and then wraps to 0.
- R11: With `cka_i` driven from `hi_q_o[2]` and the count applied to `ckb_i`, `lo_q_o` has a period of ten input falls. It is high for five of them and low for five.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock. Both count inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cka_i | input | 1 | Count input of the divide-by-two section (counts on falling edges) |
| ckb_i | input | 1 | Count input of the divide-by-five section (counts on falling edges) |
| clr_a_i | input | 1 | Clear gate input A |
| clr_b_i | input | 1 | Clear gate input B |
| set_a_i | input | 1 | Preset-to-nine gate input A |
| set_b_i | input | 1 | Preset-to-nine gate input B |
| lo_q_o | output | 1 | Divide-by-two output (weight 1) |
| hi_q_o | output | HI_W (3) | Divide-by-five output (weights 2, 4, 8) |

## Verification
The bench builds the block with its default high-section modulus of five. That setting gives a three-bit high section whose top bit can drive the low count input, which brings both the 8421 decade order and the symmetric bi-quinary order within reach. It also makes the preset value equal nine.

The bench wires each strap around the block. It checks both modes past their wrap points. It also checks the override priorities and which edges are discarded during overrides in the unstrapped mode.

// File: rtl/tsc_pkg.sv
// Package: types shared by the two-section counter.
// Assumes: no other block depends on the encoding of ovr_e.
package tsc_pkg;

    // Override requested by the gated clear and preset inputs.
    typedef enum logic [1:0] {
        OVR_NONE   = 2'd0,
        OVR_CLEAR  = 2'd1,
        OVR_PRESET = 2'd2
    } ovr_e;

    // Index of each count input in the edge-detector array.
    localparam int unsigned CK_COUNT = 2;
    localparam int unsigned CK_LO    = 0;
    localparam int unsigned CK_HI    = 1;

endpackage

// File: rtl/tsc_fall_detect.sv
// Module: falling-edge detector for one count input.
// Assumes: ck_i is synchronous to clk. The first sample after reset
// never produces an edge, because the previous sample resets low.
module tsc_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic ck_i,
    output logic fall_o
);

    logic prev_q;

    // Keep the previous sample of the count input.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= ck_i;
    end

    // An edge is a high sample followed by a low one.
    always_comb fall_o = prev_q & ~ck_i;

endmodule

// File: rtl/tsc_override.sv
// Module: gating of the clear and preset requests.
// Assumes: every input of a gate must be high for that gate to act, and
// preset has priority over clear.
module tsc_override
    import tsc_pkg::*;
#(
    parameter int unsigned GATE_N = 2
) (
    input  logic [GATE_N-1:0] clr_i,
    input  logic [GATE_N-1:0] set_i,
    output ovr_e              ovr_o
);

    // Reduce each gate and apply the priority.
    always_comb begin
        if (&set_i)      ovr_o = OVR_PRESET;
        else if (&clr_i) ovr_o = OVR_CLEAR;
        else             ovr_o = OVR_NONE;
    end

endmodule

// File: rtl/tsc_toggle_stage.sv
// Module: one-bit divide-by-two section.
// Assumes: fall_i is one cycle wide. The override is applied to the output
// without delay and is also loaded into the state, so the state holds on release.
module tsc_toggle_stage
    import tsc_pkg::*;
#(
    parameter logic PRESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fall_i,
    input  ovr_e ovr_i,
    output logic q_o
);

    logic bit_q;

    // Toggle on each edge; load the override value while an override is asserted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= 1'b0;
        end else begin
            unique case (ovr_i)
                OVR_PRESET: bit_q <= PRESET_VAL;
                OVR_CLEAR:  bit_q <= 1'b0;
                default:    if (fall_i) bit_q <= ~bit_q;
            endcase
        end
    end

    // The override reaches the output without waiting for a clock edge.
    always_comb begin
        unique case (ovr_i)
            OVR_PRESET: q_o = PRESET_VAL;
            OVR_CLEAR:  q_o = 1'b0;
            default:    q_o = bit_q;
        endcase
    end

endmodule

// File: rtl/tsc_mod_stage.sv
// Module: modulo-MOD counter section in binary order.
// Assumes: PRESET_VAL < MOD, and W is wide enough to hold MOD-1.
module tsc_mod_stage
    import tsc_pkg::*;
#(
    parameter int unsigned MOD        = 5,
    parameter int unsigned W          = 3,
    parameter int unsigned PRESET_VAL = MOD - 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fall_i,
    input  ovr_e         ovr_i,
    output logic [W-1:0] q_o
);

    localparam logic [W-1:0] LAST = W'(MOD - 1);
    localparam logic [W-1:0] PSET = W'(PRESET_VAL);

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_inc;

    // Next count in the cycle, wrapping after the last state.
    always_comb cnt_inc = (cnt_q == LAST) ? '0 : cnt_q + W'(1);

    // Advance on each edge; load the override value while an override is asserted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case (ovr_i)
                OVR_PRESET: cnt_q <= PSET;
                OVR_CLEAR:  cnt_q <= '0;
                default:    if (fall_i) cnt_q <= cnt_inc;
            endcase
        end
    end

    // The override reaches the output without waiting for a clock edge.
    always_comb begin
        unique case (ovr_i)
            OVR_PRESET: q_o = PSET;
            OVR_CLEAR:  q_o = '0;
            default:    q_o = cnt_q;
        endcase
    end

endmodule

// File: rtl/twosec_counter.sv
// Module: two-section counter, with a divide-by-two and a divide-by-HI_MOD
// section on separate count inputs.
// Assumes: the count inputs are synchronous to clk. Any strap from an
// output to a count input is made outside the block.
module twosec_counter
    import tsc_pkg::*;
#(
    parameter int unsigned HI_MOD = 5,
    parameter int unsigned GATE_N = 2,
    localparam int unsigned HI_W  = (HI_MOD > 2) ? $clog2(HI_MOD) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cka_i,
    input  logic            ckb_i,
    input  logic            clr_a_i,
    input  logic            clr_b_i,
    input  logic            set_a_i,
    input  logic            set_b_i,
    output logic            lo_q_o,
    output logic [HI_W-1:0] hi_q_o
);

    localparam int unsigned HI_PRESET = HI_MOD - 1;

    logic [CK_COUNT-1:0] ck_vec;
    logic [CK_COUNT-1:0] fall_vec;
    ovr_e                ovr;

    // Gather the count inputs so that one generate loop serves both.
    always_comb ck_vec = {ckb_i, cka_i};

    for (genvar g = 0; g < CK_COUNT; g++) begin : g_edge
        tsc_fall_detect u_fall (
            .clk    (clk),
            .rst_n  (rst_n),
            .ck_i   (ck_vec[g]),
            .fall_o (fall_vec[g])
        );
    end

    tsc_override #(
        .GATE_N (GATE_N)
    ) u_ovr (
        .clr_i ({clr_b_i, clr_a_i}),
        .set_i ({set_b_i, set_a_i}),
        .ovr_o (ovr)
    );

    tsc_toggle_stage #(
        .PRESET_VAL (1'b1)
    ) u_lo (
        .clk    (clk),
        .rst_n  (rst_n),
        .fall_i (fall_vec[CK_LO]),
        .ovr_i  (ovr),
        .q_o    (lo_q_o)
    );

    tsc_mod_stage #(
        .MOD        (HI_MOD),
        .W          (HI_W),
        .PRESET_VAL (HI_PRESET)
    ) u_hi (
        .clk    (clk),
        .rst_n  (rst_n),
        .fall_i (fall_vec[CK_HI]),
        .ovr_i  (ovr),
        .q_o    (hi_q_o)
    );

endmodule

// File: rtl/tsc_checker.sv
// Module: property checker for twosec_counter, attached with bind.
// Assumes: the inputs are stable around the rising edge of clk.
module tsc_checker #(
    parameter int unsigned HI_MOD = 5,
    parameter int unsigned HI_W   = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cka_i,
    input logic            ckb_i,
    input logic            clr_a_i,
    input logic            clr_b_i,
    input logic            set_a_i,
    input logic            set_b_i,
    input logic            lo_q_o,
    input logic [HI_W-1:0] hi_q_o
);

    logic clr_on;
    logic set_on;
    logic ovr_on;

    // Gate decode, taken from the ports only.
    always_comb begin
        clr_on = clr_a_i & clr_b_i;
        set_on = set_a_i & set_b_i;
        ovr_on = clr_on | set_on;
    end

    p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_on && !set_on) |-> (lo_q_o == 1'b0 && hi_q_o == '0));

    p_preset_nine_r6: assert property (@(posedge clk) disable iff (!rst_n)
        set_on |-> (lo_q_o == 1'b1 && int'(hi_q_o) == int'(HI_MOD) - 1));

    p_preset_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_on && set_on) |-> (lo_q_o == 1'b1));

    p_hi_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(hi_q_o) < int'(HI_MOD));

    p_lo_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !ovr_on && $past(cka_i) && !cka_i)
        |=> (ovr_on || lo_q_o != $past(lo_q_o)));

    p_lo_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !ovr_on && !($past(cka_i) && !cka_i))
        |=> (ovr_on || $stable(lo_q_o)));

    p_hi_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !ovr_on && $past(ckb_i) && !ckb_i)
        |=> (ovr_on || int'(hi_q_o) == (int'($past(hi_q_o)) + 1) % int'(HI_MOD)));

    p_hi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !ovr_on && !($past(ckb_i) && !ckb_i))
        |=> (ovr_on || $stable(hi_q_o)));

endmodule

bind twosec_counter tsc_checker #(
    .HI_MOD (HI_MOD),
    .HI_W   (HI_W)
) u_tsc_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cka_i   (cka_i),
    .ckb_i   (ckb_i),
    .clr_a_i (clr_a_i),
    .clr_b_i (clr_b_i),
    .set_a_i (set_a_i),
    .set_b_i (set_b_i),
    .lo_q_o  (lo_q_o),
    .hi_q_o  (hi_q_o)
);

// File: tb/test_twosec_counter.sv
// Bench: scoreboard check of twosec_counter, unstrapped and in both strapped modes.
module test_twosec_counter;

    localparam int HI_MOD = 5;
    localparam int HI_W   = $clog2(HI_MOD);

    typedef enum int {STRAP_NONE, STRAP_BCD, STRAP_BQ} strap_e;
    typedef struct {
        logic            lo;
        logic [HI_W-1:0] hi;
        string           tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            cka_drv, ckb_drv;
    logic            cka_w, ckb_w;
    logic            clr_a, clr_b, set_a, set_b;
    logic            lo_q;
    logic [HI_W-1:0] hi_q;
    strap_e          strap;

    exp_t sb_q[$];
    event sample_ev;
    int   checks   = 0;
    int   failures = 0;

    // 50 MHz clock.
    always #10 clk = ~clk;

    // Wiring outside the block that selects the counting mode.
    assign cka_w = (strap == STRAP_BQ)  ? hi_q[HI_W-1] : cka_drv;
    assign ckb_w = (strap == STRAP_BCD) ? lo_q         : ckb_drv;

    twosec_counter #(.HI_MOD(HI_MOD)) i_twosec_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .cka_i   (cka_w),
        .ckb_i   (ckb_w),
        .clr_a_i (clr_a),
        .clr_b_i (clr_b),
        .set_a_i (set_a),
        .set_b_i (set_b),
        .lo_q_o  (lo_q),
        .hi_q_o  (hi_q)
    );

    // Monitor: take each expected item and compare it with the outputs.
    initial begin
        forever begin
            @(sample_ev);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (lo_q !== e.lo || hi_q !== e.hi) begin
                    failures++;
                    $display("FAIL %s: got lo=%0b hi=%0d, expected lo=%0b hi=%0d",
                             e.tag, lo_q, hi_q, e.lo, e.hi);
                end
            end
        end
    end

    task automatic expect_out(input logic lo, input int hi, input string tag);
        exp_t e;
        e.lo  = lo;
        e.hi  = HI_W'(hi);
        e.tag = tag;
        sb_q.push_back(e);
        ->sample_ev;
        #1;
    endtask

    task automatic check_int(input int got, input int exp, input string tag);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s: got %0d, expected %0d", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_a();
        @(negedge clk) cka_drv = 1'b1;
        idle(2);
        cka_drv = 1'b0;
        idle(4);
    endtask

    task automatic pulse_b();
        @(negedge clk) ckb_drv = 1'b1;
        idle(2);
        ckb_drv = 1'b0;
        idle(4);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Driver: stimulus and the expected values from the requirements.
    initial begin
        int v;
        int rlo;
        int rhi;
        int highs;
        rst_n = 1'b0; strap = STRAP_NONE;
        cka_drv = 1'b0; ckb_drv = 1'b0;
        clr_a = 1'b0; clr_b = 1'b0; set_a = 1'b0; set_b = 1'b0;
        idle(5);
        rst_n = 1'b1;
        idle(1);
        expect_out(1'b0, 0, "R1 reset state");

        // R2: toggle on falls, no effect from rises.
        pulse_a(); expect_out(1'b1, 0, "R2 first fall");
        pulse_a(); expect_out(1'b0, 0, "R2 second fall");
        @(negedge clk) cka_drv = 1'b1;
        idle(4); expect_out(1'b0, 0, "R2 rise ignored");
        cka_drv = 1'b0;
        idle(4); expect_out(1'b1, 0, "R2 fall after rise");

        // R3: high section steps and wraps.
        for (int k = 1; k <= 6; k++) begin
            pulse_b();
            expect_out(1'b1, k % HI_MOD, "R3 step");
        end

        // R5: a single clear input has no effect.
        @(negedge clk) clr_a = 1'b1;
        idle(3); expect_out(1'b1, 1, "R5 clr_a alone");
        pulse_a(); expect_out(1'b0, 1, "R5 counting with clr_a");
        @(negedge clk) begin clr_a = 1'b0; clr_b = 1'b1; end
        pulse_b(); expect_out(1'b0, 2, "R5 counting with clr_b");
        clr_b = 1'b0;

        // R7: a single preset input has no effect.
        @(negedge clk) set_a = 1'b1;
        idle(3); expect_out(1'b0, 2, "R7 set_a alone");
        pulse_b(); expect_out(1'b0, 3, "R7 counting with set_a");
        @(negedge clk) begin set_a = 1'b0; set_b = 1'b1; end
        pulse_a(); expect_out(1'b1, 3, "R7 counting with set_b");
        set_b = 1'b0;

        // R4: clear in the same cycle, then held.
        @(negedge clk) begin clr_a = 1'b1; clr_b = 1'b1; end
        #1 expect_out(1'b0, 0, "R4 immediate clear");
        idle(3); expect_out(1'b0, 0, "R4 clear held");

        // R9: falls during clear are discarded.
        pulse_a(); pulse_b();
        expect_out(1'b0, 0, "R9 falls ignored under clear");
        @(negedge clk) begin clr_a = 1'b0; clr_b = 1'b0; end
        idle(3); expect_out(1'b0, 0, "R9 state after release");
        pulse_a(); expect_out(1'b1, 0, "R9 resume low");
        pulse_b(); expect_out(1'b1, 1, "R9 resume high");

        // R6: preset to nine.
        @(negedge clk) begin set_a = 1'b1; set_b = 1'b1; end
        #1 expect_out(1'b1, 4, "R6 immediate preset");
        pulse_b(); expect_out(1'b1, 4, "R9 fall ignored under preset");
        @(negedge clk) begin set_a = 1'b0; set_b = 1'b0; end
        idle(3); expect_out(1'b1, 4, "R6 nine held after release");
        pulse_b(); expect_out(1'b1, 0, "R6 high wraps from four");
        pulse_a(); expect_out(1'b0, 0, "R6 low after preset");

        // R8: preset wins over clear.
        @(negedge clk) begin clr_a = 1'b1; clr_b = 1'b1; set_a = 1'b1; set_b = 1'b1; end
        #1 expect_out(1'b1, 4, "R8 preset over clear");
        @(negedge clk) set_a = 1'b0;
        #1 expect_out(1'b0, 0, "R8 clear once preset drops");

        // R10: decade strap, changed while clear is held.
        strap = STRAP_BCD; cka_drv = 1'b0;
        idle(3);
        @(negedge clk) begin clr_a = 1'b0; clr_b = 1'b0; set_b = 1'b0; end
        idle(3); expect_out(1'b0, 0, "R10 start");
        v = 0;
        for (int k = 1; k <= 12; k++) begin
            pulse_a();
            v = (v + 1) % 10;
            expect_out(v[0], v >> 1, "R10 decade order");
        end
        @(negedge clk) begin set_a = 1'b1; set_b = 1'b1; end
        idle(3);
        @(negedge clk) begin set_a = 1'b0; set_b = 1'b0; end
        idle(3); expect_out(1'b1, 4, "R10 preset nine");
        pulse_a(); expect_out(1'b0, 0, "R10 nine wraps to zero");

        // R11: bi-quinary strap, changed while clear is held.
        @(negedge clk) begin clr_a = 1'b1; clr_b = 1'b1; end
        strap = STRAP_BQ; ckb_drv = 1'b0;
        idle(3);
        @(negedge clk) begin clr_a = 1'b0; clr_b = 1'b0; end
        idle(3); expect_out(1'b0, 0, "R11 start");
        rlo = 0; rhi = 0; highs = 0;
        for (int k = 1; k <= 20; k++) begin
            pulse_b();
            if (rhi == HI_MOD - 1) begin
                rhi = 0;
                rlo = 1 - rlo;
            end else begin
                rhi = rhi + 1;
            end
            expect_out(rlo[0], rhi, "R11 bi-quinary order");
            if (k <= 10 && lo_q === 1'b1) highs++;
        end
        check_int(highs, 5, "R11 high for five of ten");

        idle(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule